// File: doc/BRIEF.md
# DCC Byte Serializer with Underflow Fill

This block sits between a host that supplies command bytes and a DCC waveform generator that turns single bits into timed half-cycles. The generator reports each rising edge (`wave_rise`) and each falling edge (`wave_fall`) of the track waveform as a one-cycle strobe. The block puts the bit being sent on `tx_bit`, most significant bit first, and moves to the next bit on every rising strobe. A bit counter tracks where the current byte stands. The next byte is committed halfway through the last bit of the current byte and loaded on the following rising edge, so consecutive bytes run back to back with no gap.

When no byte is waiting at the commit point, the block stays on the last bit position and shifts out zeros. It also sets a sticky `underflow` flag, which software clears by pulling `clr_underflow_n` low. Software may arm an oscilloscope trigger before it hands over a byte. The trigger then gives one high pulse covering the second half of the bit before that byte, and the pulse ends on the rising edge where the byte's first bit starts.

A four-state controller drives the sequencing:
- `ST_SENDING`: the counter is below its top value. On the rising strobe that brings the counter to the top, it moves to `ST_LAST_BIT`.
- `ST_LAST_BIT`: the last bit is on the line. On a falling strobe it moves to `ST_LOAD_PEND` if the synchronized ready flag is set. Otherwise it moves to `ST_STARVED` and sets `underflow`.
- `ST_LOAD_PEND`: a load is committed. On the next rising strobe the byte is loaded, the counter is preset, `host_ack` pulses, and the controller moves to `ST_SENDING`.
- `ST_STARVED`: a zero bit is being sent. On the next rising strobe the counter holds at its top value and the controller returns to `ST_LAST_BIT`.

Top module: `dcc_byte_serializer`

## Requirements
- R1: After a synchronous reset (`rst` high for at least two clocks), `tx_bit`, `underflow`, `scope_trig` and `host_ack` are 0 and the counter stands at its top value. The first falling strobe after reset is therefore a commit point: it loads a ready byte, or it flags underflow if no byte is ready.
- R2: `tx_bit` changes only in the clock after a rising strobe. A loaded byte appears most significant bit first, and each rising strobe advances one bit.
- R3: A byte occupies exactly 8 rising strobes, counting the one that loads it. The next byte loads on the ninth rising strobe, with no extra bit between the two bytes.
- R4: `host_avail` passes through one synchronizer flop, and the ready decision is taken on the falling strobe of the last bit. On the loading rising strobe, `host_ack` goes high for exactly one clock in the following cycle.
- R5: If ready is clear at the commit point, `underflow` is set in the clock after that falling strobe. The line then carries 0 bits while the block repeats the commit decision on every falling strobe.
- R6: `underflow` stays at 1 until a clock in which `clr_underflow_n` is 0. That clock clears it, unless a new underflow occurs in the same clock.
- R7: If `arm_scope` was pulsed before the commit, `scope_trig` is 1 from the clock after the committing falling strobe until the clock after the loading rising strobe, and is 0 at all other times.
- R8: One arm triggers one load only. The next byte, sent without a new arm, produces no trigger. A byte sent without an arm produces no trigger.
- R9: `host_avail` must be high for at least one clock before the committing falling strobe. If it rises in the same clock as that strobe, the block flags underflow and loads the byte at the next commit point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wave_rise | input | 1 | One-cycle strobe: waveform rising edge |
| wave_fall | input | 1 | One-cycle strobe: waveform falling edge |
| tx_bit | output | 1 | Bit currently sent to the waveform generator |
| host_data | input | 8 | Byte offered by the host, held until acknowledged |
| host_avail | input | 1 | Host has a byte waiting |
| host_ack | output | 1 | One-cycle pulse: byte taken |
| arm_scope | input | 1 | Arms the trigger for the next loaded byte |
| scope_trig | output | 1 | Oscilloscope trigger pulse |
| clr_underflow_n | input | 1 | Active-low clear of the underflow flag |
| underflow | output | 1 | Sticky flag: a byte was not ready in time |

## Verification
Several properties are checked on every clock:
- `tx_bit` changes only after a rising strobe.
- `host_ack` is a single-cycle pulse that follows a rising strobe.
- The trigger starts only after a falling strobe and ends only after a rising strobe.
- `underflow` is set only at a falling strobe and stays set until it is cleared.

Only the bench scenarios can show the rest. These cover the bit order of real bytes, back-to-back loading with no gap, the zero fill and the repeated commit decision during starvation, the single use of an arm, and the late-host case. Each of these depends on values carried across many strobes.

// File: rtl/dcc_ser_pkg.sv
package dcc_ser_pkg;

    // Controller states of the byte serializer
    typedef enum logic [1:0] {
        ST_SENDING   = 2'd0,   // counter below top, shifting bits
        ST_LAST_BIT  = 2'd1,   // last bit of byte on the line, awaiting commit
        ST_LOAD_PEND = 2'd2,   // byte committed, load on next rising strobe
        ST_STARVED   = 2'd3    // no byte was ready, zero bit being sent
    } ser_state_e;

endpackage

// File: rtl/dcc_ready_sync.sv
// Synchronizer for the host's byte-available signal, with a clear
// that holds every stage low while a load is pending.
module dcc_ready_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic async_in,
    output logic ready_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst || clear) chain_q <= '0;
                else              chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst || clear) chain_q <= '0;
                else              chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign ready_o = chain_q[STAGES-1];

endmodule

// File: rtl/dcc_bit_counter.sv
// Bit position counter: preset on load, saturating increment on advance.
module dcc_bit_counter #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             preset,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_top_o
);

    localparam logic [CNT_W-1:0] TOP    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PRESET = CNT_W'((1 << CNT_W) - BYTE_W);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= TOP;
        else if (preset)                  cnt_q <= PRESET;
        else if (advance && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o    = cnt_q;
    assign at_top_o = (cnt_q == TOP);

endmodule

// File: rtl/dcc_shifter.sv
// Parallel-load shift register, zero fed at the serial end.
module dcc_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] din,
    output logic              msb_o
);

    logic [BYTE_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)        sh_q <= '0;
        else if (load)  sh_q <= din;
        else if (shift) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end

    assign msb_o = sh_q[BYTE_W-1];

endmodule

// File: rtl/dcc_byte_serializer.sv
module dcc_byte_serializer
    import dcc_ser_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wave_rise,
    input  logic              wave_fall,
    output logic              tx_bit,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              host_avail,
    output logic              host_ack,
    input  logic              arm_scope,
    output logic              scope_trig,
    input  logic              clr_underflow_n,
    output logic              underflow
);

    localparam int              CNT_W = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] PENULT = {{(CNT_W-1){1'b1}}, 1'b0};

    ser_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic             cnt_top;
    logic             ready;
    logic             do_load;
    logic             commit;
    logic             starve;
    logic             arm_q;
    logic             scope_q;
    logic             ack_q;
    logic             uf_q;

    // Event decode
    assign do_load = (state_q == ST_LOAD_PEND) && wave_rise;
    assign commit  = (state_q == ST_LAST_BIT) && wave_fall && ready;
    assign starve  = (state_q == ST_LAST_BIT) && wave_fall && !ready;

    dcc_ready_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst      (rst),
        .clear    (state_q == ST_LOAD_PEND),
        .async_in (host_avail),
        .ready_o  (ready)
    );

    dcc_bit_counter #(
        .BYTE_W (BYTE_W)
    ) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .preset   (do_load),
        .advance  (wave_rise && !do_load),
        .cnt_o    (cnt),
        .at_top_o (cnt_top)
    );

    dcc_shifter #(
        .BYTE_W (BYTE_W)
    ) i_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (do_load),
        .shift (wave_rise && !do_load),
        .din   (host_data),
        .msb_o (tx_bit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LAST_BIT;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SENDING: begin
                if (wave_rise && (cnt == PENULT || cnt_top))
                    state_d = ST_LAST_BIT;
            end
            ST_LAST_BIT: begin
                if (wave_fall)
                    state_d = ready ? ST_LOAD_PEND : ST_STARVED;
            end
            ST_LOAD_PEND: begin
                if (wave_rise)
                    state_d = ST_SENDING;
            end
            ST_STARVED: begin
                if (wave_rise)
                    state_d = ST_LAST_BIT;
            end
            default: state_d = ST_LAST_BIT;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            uf_q    <= 1'b0;
            arm_q   <= 1'b0;
            scope_q <= 1'b0;
        end else begin
            ack_q <= do_load;
            uf_q  <= starve | (uf_q & clr_underflow_n);
            if (do_load)        arm_q <= 1'b0;
            else if (arm_scope) arm_q <= 1'b1;
            if (do_load)              scope_q <= 1'b0;
            else if (commit && arm_q) scope_q <= 1'b1;
        end
    end

    assign host_ack   = ack_q;
    assign underflow  = uf_q;
    assign scope_trig = scope_q;

endmodule

// File: rtl/dcc_ser_checker.sv
module dcc_ser_checker (
    input logic clk,
    input logic rst,
    input logic wave_rise,
    input logic wave_fall,
    input logic tx_bit,
    input logic host_ack,
    input logic scope_trig,
    input logic clr_underflow_n,
    input logic underflow
);

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(wave_rise && wave_fall));

    p_tx_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(wave_rise) |-> $stable(tx_bit));

    p_ack_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> $past(wave_rise));

    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    p_uf_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(underflow) |-> $past(wave_fall));

    p_uf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        underflow && clr_underflow_n |=> underflow);

    p_scope_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(scope_trig) |-> $past(wave_fall));

    p_scope_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(scope_trig) |-> $past(wave_rise));

endmodule

bind dcc_byte_serializer dcc_ser_checker i_chk (
    .clk             (clk),
    .rst             (rst),
    .wave_rise       (wave_rise),
    .wave_fall       (wave_fall),
    .tx_bit          (tx_bit),
    .host_ack        (host_ack),
    .scope_trig      (scope_trig),
    .clr_underflow_n (clr_underflow_n),
    .underflow       (underflow)
);

// File: tb/test_dcc_byte_serializer.sv
module test_dcc_byte_serializer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wave_rise = 1'b0;
    logic       wave_fall = 1'b0;
    logic       tx_bit;
    logic [7:0] host_data = 8'h00;
    logic       host_avail = 1'b0;
    logic       host_ack;
    logic       arm_scope = 1'b0;
    logic       scope_trig;
    logic       clr_underflow_n = 1'b1;
    logic       underflow;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dcc_byte_serializer i_dcc_byte_serializer (
        .clk             (clk),
        .rst             (rst),
        .wave_rise       (wave_rise),
        .wave_fall       (wave_fall),
        .tx_bit          (tx_bit),
        .host_data       (host_data),
        .host_avail      (host_avail),
        .host_ack        (host_ack),
        .arm_scope       (arm_scope),
        .scope_trig      (scope_trig),
        .clr_underflow_n (clr_underflow_n),
        .underflow       (underflow)
    );

    // Stimulus vectors: bit 8 = arm before byte (expected trigger), bits 7:0 = byte
    localparam logic [8:0] VEC [5] = '{9'h0A5, 9'h13C, 9'h0FF, 9'h100, 9'h181};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fall();
        @(negedge clk) wave_fall = 1'b1;
        @(negedge clk) wave_fall = 1'b0;
    endtask

    task automatic do_rise();
        @(negedge clk) wave_rise = 1'b1;
        @(negedge clk) wave_rise = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Offer a byte before the commit point and follow all eight bits out
    task automatic send_byte(input logic [7:0] d, input logic arm);
        if (arm) begin
            @(negedge clk) arm_scope = 1'b1;
            @(negedge clk) arm_scope = 1'b0;
        end
        @(negedge clk) begin host_data = d; host_avail = 1'b1; end
        @(negedge clk);
        do_fall();
        chk("R7/R8 trigger after commit", 8'(scope_trig), 8'(arm));
        do_rise();
        chk("R4 ack on load", 8'(host_ack), 8'h01);
        chk("R7 trigger ends at load", 8'(scope_trig), 8'h00);
        chk("R2 msb first", 8'(tx_bit), 8'(d[7]));
        host_avail = 1'b0;
        for (int k = 6; k >= 0; k--) begin
            do_fall();
            if (k == 6) chk("R4 ack one cycle", 8'(host_ack), 8'h00);
            do_rise();
            chk("R3 bit sequence", 8'(tx_bit), 8'(d[k]));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        apply_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 tx after reset", 8'(tx_bit), 8'h00);
        chk("R1 underflow after reset", 8'(underflow), 8'h00);
        chk("R1 trigger after reset", 8'(scope_trig), 8'h00);
        chk("R1 ack after reset", 8'(host_ack), 8'h00);

        // Table walk: back-to-back bytes, first one loads at R1 commit point
        for (int v = 0; v < 5; v++) begin
            send_byte(VEC[v][7:0], VEC[v][8]);
        end
        chk("R3 no underflow back to back", 8'(underflow), 8'h00);

        // R5 starvation: zero fill, flag set
        do_fall();
        chk("R5 underflow set", 8'(underflow), 8'h01);
        do_rise();
        chk("R5 zero fill bit 1", 8'(tx_bit), 8'h00);
        do_fall();
        do_rise();
        chk("R5 zero fill bit 2", 8'(tx_bit), 8'h00);
        chk("R8 no trigger when starved", 8'(scope_trig), 8'h00);
        repeat (4) @(negedge clk);
        chk("R6 underflow sticky", 8'(underflow), 8'h01);
        clr_underflow_n = 1'b0;
        @(negedge clk) clr_underflow_n = 1'b1;
        chk("R6 underflow cleared", 8'(underflow), 8'h00);

        // R9 late host: avail rises with the committing strobe
        @(negedge clk) begin host_data = 8'hC3; host_avail = 1'b1; wave_fall = 1'b1; end
        @(negedge clk) wave_fall = 1'b0;
        chk("R9 late host underflows", 8'(underflow), 8'h01);
        do_rise();
        chk("R9 zero bit while late", 8'(tx_bit), 8'h00);
        chk("R9 no ack while late", 8'(host_ack), 8'h00);
        do_fall();
        do_rise();
        chk("R9 late byte acked", 8'(host_ack), 8'h01);
        chk("R9 late byte msb", 8'(tx_bit), 8'h01);
        host_avail = 1'b0;
        for (int k = 6; k >= 0; k--) begin
            do_fall();
            do_rise();
            chk("R9 late byte bits", 8'(tx_bit), 8'(8'hC3 >> k) & 8'h01);
        end
        clr_underflow_n = 1'b0;
        @(negedge clk) clr_underflow_n = 1'b1;

        // R1 mid-run reset: counter back at top, first fall is a commit point
        send_byte(8'h5A, 1'b1);
        do_fall();
        do_rise();
        apply_reset();
        @(negedge clk);
        chk("R1 tx after mid reset", 8'(tx_bit), 8'h00);
        chk("R1 underflow after mid reset", 8'(underflow), 8'h00);
        do_fall();
        chk("R1 counter at top after reset", 8'(underflow), 8'h01);
        chk("R8 arm cleared by reset", 8'(scope_trig), 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule